// File: doc/BRIEF.md
# MAC Table Aging Scanner

This block ages the learned entries of a MAC address table. A free-running period timer counts time-base pulses: one-second pulses in normal operation, or one-millisecond pulses when the test-mode input is high. When the count reaches the programmed aging time, the block walks the whole table from the lowest address to the highest. It uses a shared read/modify/write port, and an arbiter grants that port one access at a time.

For every entry that is valid and not static, the scanner writes the entry back. If the entry's 2-bit age is above zero, the write-back carries the age lowered by one. If the age is already zero, the write-back clears the entry's valid bit. A refresh from the learning logic (outside this block) sets the age to 3. An entry that is never refreshed is therefore removed by the fourth scan, so it lives between three and four programmed periods. An aging period that expires while a scan is running is held and starts a new scan as soon as the current one ends. Several expiries during one scan merge into a single pending scan.

Table word layout as seen by the scanner: bit ENTRY_W-1 is the valid flag, bit ENTRY_W-2 is the static flag, bits ENTRY_W-3:ENTRY_W-4 are the age, and the lower bits are payload that the scanner never alters.

Top module: `aging_scanner`

## Requirements
- R1: While reset is asserted, and afterwards until a period expires, tbl_req and scan_busy are 0.
- R2: A scan starts on the clock edge that samples the Nth pulse of the selected time base, where N = max(age_time,1). The selected base is sec_tick when test_mode=0 and ms_tick when test_mode=1. Pulses of the other base are ignored.
- R3: An age_time of 0 behaves as 1, so every selected pulse ends a period.
- R4: Each scan issues exactly ENTRIES granted reads (tbl_wr=0), at addresses 0, 1, … ENTRIES-1 in that order.
- R5: For a read word with valid=1, static=0 and age>0, the scanner writes back the same word with the age lowered by one.
- R6: For a read word with valid=1, static=0 and age=0, the scanner writes back the same word with the valid bit cleared.
- R7: A word with valid=0 or static=1 causes no write.
- R8: While tbl_req is high and tbl_gnt is low, tbl_req stays high and tbl_addr, tbl_wr and tbl_wdata hold their values in the next cycle.
- R9: Any number of period expiries during a scan cause exactly one further scan. That scan begins one idle cycle after the current scan ends.
- R10: scan_busy rises when a scan starts, stays high through its last granted access, and falls on the following edge.
- R11: An unrefreshed entry with age 3 remains valid after three scans and is removed by the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| age_time | input | TIME_W | Aging period in time-base units (0 treated as 1) |
| test_mode | input | 1 | 1 selects millisecond pulses, 0 selects second pulses |
| sec_tick | input | 1 | One-cycle pulse per second |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| tbl_gnt | input | 1 | Arbiter grant; the current access happens in this cycle |
| tbl_rdata | input | ENTRY_W | Read word, valid the cycle after a granted read |
| tbl_req | output | 1 | Table access request |
| tbl_wr | output | 1 | 1 = write access, 0 = read access |
| tbl_addr | output | clog2(ENTRIES) | Entry address |
| tbl_wdata | output | ENTRY_W | Word to write |
| scan_busy | output | 1 | High while a scan is in progress |

## Verification
The two functions that collide are the period timer and the table walk. A period can expire in any cycle of a running scan, including the cycle of its final granted access. The bench provokes this by using an aging time of 1 and sending extra selected pulses while a scan is running under random grant stalls. It judges the result in three ways: scan_busy must drop for exactly one cycle and then rise again, the table must show exactly two aging passes, and no third scan may follow.

// File: rtl/aging_pkg.sv
package aging_pkg;

  localparam int AGE_W  = 2;
  localparam int META_W = AGE_W + 2;

  typedef enum logic [1:0] {
    W_IDLE,
    W_READ,
    W_LATCH,
    W_WRITE
  } walk_state_e;

  typedef struct packed {
    logic             valid;
    logic             pinned;
    logic [AGE_W-1:0] age;
  } entry_meta_t;

  // Programmed period in units; zero is promoted to one.
  function automatic int unsigned period_limit(input int unsigned field);
    return (field == 0) ? 1 : field;
  endfunction

  // Only live, non-static entries are rewritten.
  function automatic logic meta_needs_update(input entry_meta_t m);
    return m.valid && !m.pinned;
  endfunction

  // One aging step: count the age down, or drop the entry at zero.
  function automatic entry_meta_t meta_aged(input entry_meta_t m);
    entry_meta_t r;
    r = m;
    if (m.age != '0) r.age = m.age - 1'b1;
    else             r.valid = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/aging_period_timer.sv
module aging_period_timer
  import aging_pkg::*;
#(
  parameter int TIME_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] age_time,
  input  logic              test_mode,
  input  logic              sec_tick,
  input  logic              ms_tick,
  output logic              period_done
);

  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] lim;
  logic [TIME_W:0]   next_cnt;
  logic              tick_sel;

  assign tick_sel    = test_mode ? ms_tick : sec_tick;
  assign lim         = TIME_W'(period_limit(32'(age_time)));
  assign next_cnt    = {1'b0, cnt_q} + 1'b1;
  assign period_done = tick_sel && (next_cnt >= {1'b0, lim});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (tick_sel) cnt_q <= period_done ? '0 : next_cnt[TIME_W-1:0];
  end

endmodule

// File: rtl/aging_start_ctrl.sv
module aging_start_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic period_done,
  input  logic scan_busy,
  output logic scan_start,
  output logic pend_q
);

  logic want;

  assign want       = period_done || pend_q;
  assign scan_start = want && !scan_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= want && scan_busy;
  end

endmodule

// File: rtl/aging_table_walker.sv
module aging_table_walker
  import aging_pkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int ENTRY_W = 59,
  parameter int ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_start,
  input  logic               tbl_gnt,
  input  logic [ENTRY_W-1:0] tbl_rdata,
  output logic               tbl_req,
  output logic               tbl_wr,
  output logic [ADDR_W-1:0]  tbl_addr,
  output logic [ENTRY_W-1:0] tbl_wdata,
  output logic               scan_busy,
  output logic               step_done,
  output logic               scan_end
);

  localparam int                PAY_W    = ENTRY_W - META_W;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(ENTRIES - 1);

  walk_state_e        state_q, state_d;
  logic [ADDR_W-1:0]  idx_q;
  logic [ENTRY_W-1:0] wbuf_q;
  entry_meta_t        rd_meta;
  logic               rd_touch;

  assign rd_meta  = tbl_rdata[ENTRY_W-1 -: META_W];
  assign rd_touch = meta_needs_update(rd_meta);

  always_comb begin
    state_d   = state_q;
    step_done = 1'b0;
    unique case (state_q)
      W_IDLE:  if (scan_start) state_d = W_READ;
      W_READ:  if (tbl_gnt) state_d = W_LATCH;
      W_LATCH: if (rd_touch) state_d = W_WRITE;
               else step_done = 1'b1;
      W_WRITE: if (tbl_gnt) step_done = 1'b1;
      default: state_d = W_IDLE;
    endcase
    scan_end = step_done && (idx_q == LAST_IDX);
    if (step_done) state_d = scan_end ? W_IDLE : W_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      idx_q   <= '0;
      wbuf_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == W_IDLE && scan_start) idx_q <= '0;
      else if (step_done && !scan_end)     idx_q <= idx_q + 1'b1;
      if (state_q == W_LATCH && rd_touch)
        wbuf_q <= {meta_aged(rd_meta), tbl_rdata[PAY_W-1:0]};
    end
  end

  assign tbl_req   = (state_q == W_READ) || (state_q == W_WRITE);
  assign tbl_wr    = (state_q == W_WRITE);
  assign tbl_addr  = idx_q;
  assign tbl_wdata = wbuf_q;
  assign scan_busy = (state_q != W_IDLE);

endmodule

// File: rtl/aging_scanner.sv
module aging_scanner
  import aging_pkg::*;
#(
  parameter  int ENTRIES = 512,
  parameter  int ENTRY_W = 59,
  parameter  int TIME_W  = 12,
  localparam int ADDR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIME_W-1:0]  age_time,
  input  logic               test_mode,
  input  logic               sec_tick,
  input  logic               ms_tick,
  input  logic               tbl_gnt,
  input  logic [ENTRY_W-1:0] tbl_rdata,
  output logic               tbl_req,
  output logic               tbl_wr,
  output logic [ADDR_W-1:0]  tbl_addr,
  output logic [ENTRY_W-1:0] tbl_wdata,
  output logic               scan_busy
);

  // Internal events, named for the checker.
  logic period_done;
  logic scan_start;
  logic pend_q;
  logic step_done;
  logic scan_end;

  aging_period_timer #(.TIME_W(TIME_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .age_time    (age_time),
    .test_mode   (test_mode),
    .sec_tick    (sec_tick),
    .ms_tick     (ms_tick),
    .period_done (period_done)
  );

  aging_start_ctrl u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_done (period_done),
    .scan_busy   (scan_busy),
    .scan_start  (scan_start),
    .pend_q      (pend_q)
  );

  aging_table_walker #(
    .ENTRIES (ENTRIES),
    .ENTRY_W (ENTRY_W),
    .ADDR_W  (ADDR_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_start (scan_start),
    .tbl_gnt    (tbl_gnt),
    .tbl_rdata  (tbl_rdata),
    .tbl_req    (tbl_req),
    .tbl_wr     (tbl_wr),
    .tbl_addr   (tbl_addr),
    .tbl_wdata  (tbl_wdata),
    .scan_busy  (scan_busy),
    .step_done  (step_done),
    .scan_end   (scan_end)
  );

endmodule

// File: rtl/aging_scanner_chk.sv
module aging_scanner_chk #(
  parameter int ENTRY_W = 59,
  parameter int ADDR_W  = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tbl_req,
  input logic               tbl_wr,
  input logic               tbl_gnt,
  input logic [ADDR_W-1:0]  tbl_addr,
  input logic [ENTRY_W-1:0] tbl_wdata,
  input logic               scan_busy,
  input logic               scan_start,
  input logic               pend_q,
  input logic               step_done,
  input logic               scan_end
);

  logic       w_valid, w_pinned;
  logic [1:0] w_age;
  assign w_valid  = tbl_wdata[ENTRY_W-1];
  assign w_pinned = tbl_wdata[ENTRY_W-2];
  assign w_age    = tbl_wdata[ENTRY_W-3 -: 2];

  // R8
  hold_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req && !tbl_gnt |=> tbl_req && $stable(tbl_addr) && $stable(tbl_wr) && $stable(tbl_wdata));

  // R10
  req_inside_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req |-> scan_busy);

  // R10
  busy_drops_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |=> !scan_busy);

  // R4
  scan_opens_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_busy) |-> tbl_req && !tbl_wr && (tbl_addr == '0));

  // R4
  next_entry_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done && !scan_end |=> tbl_req && !tbl_wr && (tbl_addr == $past(tbl_addr) + 1'b1));

  // R2
  start_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_busy) |-> $past(scan_start));

  // R7
  no_static_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req && tbl_wr |-> !w_pinned);

  // R6
  removal_at_age_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req && tbl_wr && !w_valid |-> w_age == 2'd0);

  // R5
  kept_entry_aged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req && tbl_wr && w_valid |-> w_age != 2'd3);

  // R9
  pending_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !scan_busy |=> scan_busy);

endmodule

bind aging_scanner aging_scanner_chk #(
  .ENTRY_W (ENTRY_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tbl_req    (tbl_req),
  .tbl_wr     (tbl_wr),
  .tbl_gnt    (tbl_gnt),
  .tbl_addr   (tbl_addr),
  .tbl_wdata  (tbl_wdata),
  .scan_busy  (scan_busy),
  .scan_start (scan_start),
  .pend_q     (pend_q),
  .step_done  (step_done),
  .scan_end   (scan_end)
);

// File: tb/sim_aging_scanner.sv
module sim_aging_scanner;

  localparam int N  = 16;
  localparam int EW = 59;
  localparam int AW = 4;
  localparam int TW = 12;
  localparam int VB = EW - 1;   // valid flag
  localparam int SB = EW - 2;   // static flag
  localparam int AH = EW - 3;   // age high bit
  localparam int AL = EW - 4;   // age low bit

  logic          clk = 1'b0;
  logic          rst_n;
  logic [TW-1:0] age_time;
  logic          test_mode, sec_tick, ms_tick, tbl_gnt;
  logic [EW-1:0] tbl_rdata;
  logic          tbl_req, tbl_wr, scan_busy;
  logic [AW-1:0] tbl_addr;
  logic [EW-1:0] tbl_wdata;

  always #5 clk = ~clk;

  aging_scanner #(.ENTRIES(N), .ENTRY_W(EW), .TIME_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .age_time(age_time), .test_mode(test_mode),
    .sec_tick(sec_tick), .ms_tick(ms_tick), .tbl_gnt(tbl_gnt), .tbl_rdata(tbl_rdata),
    .tbl_req(tbl_req), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .scan_busy(scan_busy)
  );

  int checks = 0, errors = 0;
  int grant_pct = 60;
  int rd_cnt = 0, wr_cnt = 0, exp_rd = 0, ord_bad = 0, hold_bad = 0;
  logic [EW-1:0] mem  [N];
  logic [EW-1:0] snap [N];

  // Table model: one access per granted cycle, read data one cycle later.
  always @(posedge clk) begin
    if (tbl_req && tbl_gnt) begin
      if (tbl_wr) mem[tbl_addr] <= tbl_wdata;
      else        tbl_rdata     <= mem[tbl_addr];
    end
  end

  // Arbiter stand-in and access monitor.
  logic          p_wait = 1'b0, p_wr;
  logic [AW-1:0] p_addr;
  logic [EW-1:0] p_wdata;
  always @(negedge clk) begin
    tbl_gnt = ($urandom_range(99) < grant_pct);
    #1;
    if (rst_n) begin
      if (p_wait && (!tbl_req || tbl_addr != p_addr || tbl_wr != p_wr || tbl_wdata != p_wdata))
        hold_bad++;
      if (tbl_req && tbl_gnt) begin
        if (tbl_wr) wr_cnt++;
        else begin
          if (int'(tbl_addr) != exp_rd) ord_bad++;
          exp_rd = (exp_rd + 1) % N;
          rd_cnt++;
        end
      end
      p_wait  = tbl_req && !tbl_gnt;
      p_addr  = tbl_addr;
      p_wr    = tbl_wr;
      p_wdata = tbl_wdata;
    end
  end

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] age_once(input logic [EW-1:0] w);
    logic [1:0] a;
    a = w[AH:AL];
    if (w[VB] == 1'b0 || w[SB] == 1'b1) return w;
    if (a == 2'd0) w[VB] = 1'b0;
    else           w[AH:AL] = a - 2'd1;
    return w;
  endfunction

  function automatic logic [EW-1:0] mk(input bit v, input bit s, input logic [1:0] a);
    logic [EW-1:0] w;
    w = {$urandom(), $urandom()};
    w[VB] = v; w[SB] = s; w[AH:AL] = a;
    return w;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < N; i++)
      mem[i] = mk($urandom_range(3) != 0, $urandom_range(4) == 0, 2'($urandom_range(3)));
    // Guarantee each class once.
    mem[0] = mk(1, 0, 2'd0);
    mem[1] = mk(1, 0, 2'd3);
    mem[2] = mk(1, 1, 2'd0);
    mem[3] = mk(0, 0, 2'd2);
  endtask

  task automatic tick(input bit use_ms);
    @(negedge clk);
    if (use_ms) ms_tick = 1'b1; else sec_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0; sec_tick = 1'b0;
    #2;
  endtask

  task automatic wait_idle();
    while (scan_busy) @(negedge clk);
    #2;
  endtask

  int rd0, wr0, ord0, hold0;
  task automatic mark();
    for (int i = 0; i < N; i++) snap[i] = mem[i];
    rd0 = rd_cnt; wr0 = wr_cnt; ord0 = ord_bad; hold0 = hold_bad;
  endtask

  // Compare table after `passes` aging passes since mark().
  task automatic judge(input string tag, input int passes);
    int bad, exp_wr, first;
    logic [EW-1:0] e;
    bad = 0; exp_wr = 0; first = -1;
    for (int i = 0; i < N; i++) begin
      e = snap[i];
      for (int p = 0; p < passes; p++) begin
        if (e[VB] && !e[SB]) exp_wr++;
        e = age_once(e);
      end
      if (mem[i] !== e) begin bad++; if (first < 0) first = i; end
    end
    chk({tag, " R4 read count"}, rd_cnt - rd0 == N * passes, rd_cnt - rd0, N * passes);
    chk({tag, " R4 read order"}, ord_bad == ord0, ord_bad - ord0, 0);
    chk({tag, " R5/R6 table contents"}, bad == 0, bad, 0);
    chk({tag, " R7 write count"}, wr_cnt - wr0 == exp_wr, wr_cnt - wr0, exp_wr);
    chk({tag, " R8 request hold"}, hold_bad == hold0, hold_bad - hold0, 0);
  endtask

  bit done = 1'b0;

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; age_time = '0; test_mode = 1'b0; sec_tick = 1'b0; ms_tick = 1'b0;
    tbl_gnt = 1'b0; tbl_rdata = '0;
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    #2;
    chk("R1 req in reset", tbl_req == 1'b0, tbl_req, 0);
    chk("R1 busy in reset", scan_busy == 1'b0, scan_busy, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #2;
    chk("R1 idle after reset", !tbl_req && !scan_busy, {tbl_req, scan_busy}, 0);

    // R2: seconds base, period 3, ms pulses ignored.
    fill_random(); age_time = 12'd3; test_mode = 1'b0; mark();
    tick(0); tick(1); tick(1); tick(0); tick(1);
    chk("R2 no scan before 3rd second", scan_busy == 1'b0, scan_busy, 0);
    tick(0);
    chk("R2 R10 scan on 3rd second", scan_busy == 1'b1, scan_busy, 1);
    wait_idle(); judge("sec", 1);

    // R2: millisecond base, period 2, second pulses ignored.
    fill_random(); age_time = 12'd2; test_mode = 1'b1; mark();
    tick(0); tick(1); tick(0);
    chk("R2 no scan before 2nd ms", scan_busy == 1'b0, scan_busy, 0);
    tick(1);
    chk("R2 scan on 2nd ms", scan_busy == 1'b1, scan_busy, 1);
    wait_idle(); judge("ms", 1);

    // R3: zero period behaves as one.
    fill_random(); age_time = 12'd0; test_mode = 1'b0; mark();
    tick(1);
    chk("R3 ms ignored", scan_busy == 1'b0, scan_busy, 0);
    tick(0);
    chk("R3 zero as one", scan_busy == 1'b1, scan_busy, 1);
    wait_idle(); judge("zero", 1);

    // R11: fresh entries survive three scans, vanish on the fourth.
    for (int i = 0; i < N; i++) mem[i] = mk(1, 0, 2'd3);
    age_time = 12'd1;
    for (int s = 0; s < 3; s++) begin tick(0); wait_idle(); end
    chk("R11 valid after three scans", mem[5][VB] == 1'b1 && mem[5][AH:AL] == 2'd0,
        {mem[5][VB], mem[5][AH:AL]}, 3'b100);
    tick(0); wait_idle();
    chk("R11 removed by fourth scan", mem[5][VB] == 1'b0, mem[5][VB], 0);

    // R9: expiries during a scan merge into one follow-up scan.
    fill_random(); age_time = 12'd1; grant_pct = 50; mark();
    tick(0);
    repeat (3) @(negedge clk);
    tick(0);
    repeat (2) @(negedge clk);
    tick(0);
    chk("R9 first scan still running", scan_busy == 1'b1, scan_busy, 1);
    while (scan_busy) @(negedge clk);
    @(negedge clk); #2;
    chk("R9 R10 restart after one idle cycle", scan_busy == 1'b1, scan_busy, 1);
    wait_idle();
    repeat (20) @(negedge clk);
    #2;
    chk("R9 no third scan", scan_busy == 1'b0, scan_busy, 0);
    judge("merge", 2);

    // Random rounds.
    for (int r = 0; r < 12; r++) begin
      int t, lim;
      bit m;
      fill_random();
      t = $urandom_range(4); m = $urandom_range(1); lim = (t == 0) ? 1 : t;
      grant_pct = 20 + $urandom_range(80);
      age_time = TW'(t); test_mode = m;
      mark();
      for (int k = 0; k < lim - 1; k++) begin tick(m); tick(!m); end
      chk("R2 random not early", scan_busy == 1'b0, scan_busy, 0);
      tick(m);
      chk("R2 random start", scan_busy == 1'b1, scan_busy, 1);
      wait_idle(); judge("random", 1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule